// File: doc/BRIEF.md
# Pipelined Execute Stage with Exception Passthrough

This block is the execute step of an in-order processor pipeline. Each cycle it takes one decoded instruction from the decode step and registers one result for the memory step. The result carries the computed value, the register-write enable, the exception cause, the instruction address and the delay-slot flag. The arithmetic unit sits outside the block. The stage drives the unit's operands and opcode and reads back its result, its discard flag and its exception cause. The stage also has a small built-in read path for hardware registers. It returns a CPU number, the cache row size, a cycle counter, the counter resolution or a user-local value, chosen by a 5-bit selector.

An instruction can arrive already carrying an exception cause from an earlier stage. In that case the arithmetic unit is not enabled. The value goes out as zero and the earlier cause reaches the output untouched. When no cause arrives with the instruction, any cause the unit raises (such as overflow or trap) becomes the outgoing cause.

Data flows with valid/ready. `in_ready` is the inverse of `stall`. While `in_ready` is low, upstream must hold its bundle, because the stage neither samples the inputs nor changes its output register. `flush` overrides `stall` and loads an empty slot. The downstream side has no ready signal. The pipeline's hazard logic applies back-pressure through `stall` alone.

Top module: `exec_stage`

## Requirements
- R1: When `in_cause` is not 0, `alu_en` is low. The next registered `out_value` is 0, `out_cause` equals `in_cause`, and `alu_result`, `alu_cause` and `alu_discard` have no effect.
- R2: When `in_cause` is 0, `alu_en` is high and the registered `out_cause` equals `alu_cause`. For a non-hardware-register instruction, `out_value` equals `alu_result`. Cause code 0 means none; any nonzero code is passed on as it is.
- R3: When `in_cause` is 0 and `alu_discard` is high, `out_regwrite` is registered as 0. In every other case it follows `in_regwrite`.
- R4: `alu_a` equals `in_rs_val`. `alu_b` equals `in_imm` when `in_alusrc` is 1 and `in_rt_val` when it is 0. `alu_op` equals `in_aluop`.
- R5: For a hardware-register read (`in_is_hwr` high, no pending cause), `out_value` depends on `in_hwr_sel`. Selector 0 gives 0, selector 1 gives ROW_BYTES, selector 2 gives `cycle_count`, selector 3 gives 1 and selector 29 gives `user_local`.
- R6: A hardware-register read with any other selector gives `out_value` 0.
- R7: `out_pc` and `out_delay_slot` are registered copies of `in_pc` and `in_delay_slot`.
- R8: The output is registered on the rising clock edge, one cycle after the inputs. `out_valid` follows `in_valid`. A synchronous reset clears `out_valid` and sets `out_cause` to 0.
- R9: While `stall` is high and `flush` is low, every output register holds its value and `in_ready` is low.
- R10: `flush` loads an empty slot with `out_valid` 0, `out_cause` 0 and `out_regwrite` 0, even when `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the output register |
| flush | input | 1 | Load an empty slot |
| in_valid | input | 1 | Incoming bundle is valid |
| in_ready | output | 1 | Stage accepts the incoming bundle |
| in_pc | input | AW | Instruction address |
| in_delay_slot | input | 1 | Instruction sits in a delay slot |
| in_cause | input | 3 | Cause attached by earlier stages, 0 = none |
| in_regwrite | input | 1 | Instruction writes a register |
| in_alusrc | input | 1 | Second operand is the immediate |
| in_is_hwr | input | 1 | Instruction reads a hardware register |
| in_hwr_sel | input | 5 | Hardware-register selector |
| in_rs_val | input | DW | First register operand |
| in_rt_val | input | DW | Second register operand |
| in_imm | input | DW | Extended immediate |
| in_aluop | input | OPW | Arithmetic opcode |
| alu_en | output | 1 | Arithmetic unit evaluation enable |
| alu_op | output | OPW | Opcode to the arithmetic unit |
| alu_a | output | DW | First operand to the arithmetic unit |
| alu_b | output | DW | Second operand to the arithmetic unit |
| alu_result | input | DW | Result from the arithmetic unit |
| alu_discard | input | 1 | Unit asks to drop the register write |
| alu_cause | input | 3 | Cause raised by the unit |
| cycle_count | input | DW | Free-running cycle counter |
| user_local | input | DW | User-local register value |
| out_valid | output | 1 | Output bundle is valid |
| out_pc | output | AW | Registered instruction address |
| out_delay_slot | output | 1 | Registered delay-slot flag |
| out_cause | output | 3 | Registered exception cause |
| out_regwrite | output | 1 | Registered register-write enable |
| out_value | output | DW | Registered result value |

## Verification
The bench drives a pending upstream cause while the arithmetic unit reports a nonzero result, a different cause and a discard. A design that still evaluated the unit would show that result, that cause or a cleared write enable. Every selector with a fixed meaning is checked, along with two unused ones, 7 and 31. A design with a bad mux entry or a default other than zero would return the wrong value for one of them. The bench also raises `stall` and `flush` together. A design that gave `stall` priority would keep a valid slot instead of loading an empty one.

// File: rtl/exs_pkg.sv
package exs_pkg;
  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = '0;
  localparam int HWR_SEL_W = 5;
  // fixed selector meanings of the hardware-register read path
  localparam logic [HWR_SEL_W-1:0] HWR_CPU_NUM  = 5'd0;
  localparam logic [HWR_SEL_W-1:0] HWR_ROW_SIZE = 5'd1;
  localparam logic [HWR_SEL_W-1:0] HWR_CYCLES   = 5'd2;
  localparam logic [HWR_SEL_W-1:0] HWR_CNT_RES  = 5'd3;
  localparam logic [HWR_SEL_W-1:0] HWR_USER     = 5'd29;
endpackage

// File: rtl/exs_hwreg_mux.sv
module exs_hwreg_mux
  import exs_pkg::*;
#(
  parameter int DW        = 32,
  parameter int ROW_BYTES = 64
) (
  input  logic [HWR_SEL_W-1:0] sel,
  input  logic [DW-1:0]        cycle_count,
  input  logic [DW-1:0]        user_local,
  output logic [DW-1:0]        value
);
  localparam logic [DW-1:0] ROW_VAL = DW'(ROW_BYTES);
  localparam logic [DW-1:0] RES_VAL = DW'(1);

  always_comb begin
    unique case (sel)
      HWR_CPU_NUM:  value = '0;
      HWR_ROW_SIZE: value = ROW_VAL;
      HWR_CYCLES:   value = cycle_count;
      HWR_CNT_RES:  value = RES_VAL;
      HWR_USER:     value = user_local;
      default:      value = '0;
    endcase
  end
endmodule

// File: rtl/exs_merge.sv
module exs_merge
  import exs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [CAUSE_W-1:0] in_cause,
  input  logic               in_regwrite,
  input  logic               in_is_hwr,
  input  logic [DW-1:0]      hwr_value,
  input  logic [DW-1:0]      alu_result,
  input  logic               alu_discard,
  input  logic [CAUSE_W-1:0] alu_cause,
  output logic               alu_en,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [DW-1:0]      value_o,
  output logic               regwrite_o
);
  logic pending;

  always_comb begin
    pending    = (in_cause != CAUSE_NONE);
    alu_en     = !pending;
    cause_o    = pending ? in_cause : alu_cause;
    regwrite_o = in_regwrite & ~(alu_en & alu_discard);
    if (pending)        value_o = '0;
    else if (in_is_hwr) value_o = hwr_value;
    else                value_o = alu_result;
  end
endmodule

// File: rtl/exs_out_reg.sv
module exs_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stall,
  input  logic         flush,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  // an all-zero slot is the empty slot: cause none, no write
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (!stall) begin
      q_valid <= d_valid;
      q       <= d;
    end
  end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exs_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int OPW       = 6,
  parameter int ROW_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [AW-1:0]        in_pc,
  input  logic                 in_delay_slot,
  input  logic [CAUSE_W-1:0]   in_cause,
  input  logic                 in_regwrite,
  input  logic                 in_alusrc,
  input  logic                 in_is_hwr,
  input  logic [HWR_SEL_W-1:0] in_hwr_sel,
  input  logic [DW-1:0]        in_rs_val,
  input  logic [DW-1:0]        in_rt_val,
  input  logic [DW-1:0]        in_imm,
  input  logic [OPW-1:0]       in_aluop,
  output logic                 alu_en,
  output logic [OPW-1:0]       alu_op,
  output logic [DW-1:0]        alu_a,
  output logic [DW-1:0]        alu_b,
  input  logic [DW-1:0]        alu_result,
  input  logic                 alu_discard,
  input  logic [CAUSE_W-1:0]   alu_cause,
  input  logic [DW-1:0]        cycle_count,
  input  logic [DW-1:0]        user_local,
  output logic                 out_valid,
  output logic [AW-1:0]        out_pc,
  output logic                 out_delay_slot,
  output logic [CAUSE_W-1:0]   out_cause,
  output logic                 out_regwrite,
  output logic [DW-1:0]        out_value
);
  localparam int BW = AW + 1 + CAUSE_W + 1 + DW;

  logic [DW-1:0]      hwr_value;
  logic [CAUSE_W-1:0] nxt_cause;
  logic [DW-1:0]      nxt_value;
  logic               nxt_regwrite;
  logic [BW-1:0]      nxt_bundle;
  logic [BW-1:0]      cur_bundle;

  assign in_ready = !stall;
  assign alu_op   = in_aluop;
  assign alu_a    = in_rs_val;
  assign alu_b    = in_alusrc ? in_imm : in_rt_val;

  exs_hwreg_mux #(.DW(DW), .ROW_BYTES(ROW_BYTES)) hwr_i (
    .sel         (in_hwr_sel),
    .cycle_count (cycle_count),
    .user_local  (user_local),
    .value       (hwr_value)
  );

  exs_merge #(.DW(DW)) merge_i (
    .in_cause    (in_cause),
    .in_regwrite (in_regwrite),
    .in_is_hwr   (in_is_hwr),
    .hwr_value   (hwr_value),
    .alu_result  (alu_result),
    .alu_discard (alu_discard),
    .alu_cause   (alu_cause),
    .alu_en      (alu_en),
    .cause_o     (nxt_cause),
    .value_o     (nxt_value),
    .regwrite_o  (nxt_regwrite)
  );

  assign nxt_bundle = {in_pc, in_delay_slot, nxt_cause, nxt_regwrite, nxt_value};

  exs_out_reg #(.W(BW)) oreg_i (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall),
    .flush   (flush),
    .d_valid (in_valid),
    .d       (nxt_bundle),
    .q_valid (out_valid),
    .q       (cur_bundle)
  );

  assign {out_pc, out_delay_slot, out_cause, out_regwrite, out_value} = cur_bundle;
endmodule

// File: rtl/exs_checker.sv
module exs_checker
  import exs_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               stall,
  input logic               flush,
  input logic [AW-1:0]      in_pc,
  input logic [CAUSE_W-1:0] in_cause,
  input logic               alu_en,
  input logic               alu_discard,
  input logic               out_valid,
  input logic [AW-1:0]      out_pc,
  input logic [CAUSE_W-1:0] out_cause,
  input logic               out_regwrite,
  input logic [DW-1:0]      out_value
);
  AST_PENDING_GATES_ALU: assert property (@(posedge clk) disable iff (rst)
    (in_cause != CAUSE_NONE) |-> !alu_en); // R1

  AST_PENDING_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush && in_cause != CAUSE_NONE)
    |=> (out_cause == $past(in_cause) && out_value == '0)); // R1

  AST_DISCARD_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush && in_cause == CAUSE_NONE && alu_discard)
    |=> !out_regwrite); // R3

  AST_PC_CARRIED: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush) |=> (out_pc == $past(in_pc))); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($stable(out_valid) && $stable(out_pc) &&
                           $stable(out_cause) && $stable(out_value))); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && out_cause == CAUSE_NONE && !out_regwrite)); // R10
endmodule

bind exec_stage exs_checker #(.DW(DW), .AW(AW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .stall        (stall),
  .flush        (flush),
  .in_pc        (in_pc),
  .in_cause     (in_cause),
  .alu_en       (alu_en),
  .alu_discard  (alu_discard),
  .out_valid    (out_valid),
  .out_pc       (out_pc),
  .out_cause    (out_cause),
  .out_regwrite (out_regwrite),
  .out_value    (out_value)
);

// File: tb/exec_stage_tb_top.sv
`timescale 1ns/1ps
module exec_stage_tb_top;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int OPW = 6;
  localparam int ROW = 64;

  logic clk = 1'b0;
  logic rst, stall, flush, in_valid, in_ready, in_delay_slot, in_regwrite;
  logic in_alusrc, in_is_hwr, alu_en, alu_discard;
  logic [AW-1:0] in_pc, out_pc;
  logic [2:0] in_cause, alu_cause, out_cause;
  logic [4:0] in_hwr_sel;
  logic [DW-1:0] in_rs_val, in_rt_val, in_imm, alu_a, alu_b, alu_result;
  logic [DW-1:0] cycle_count, user_local, out_value;
  logic [OPW-1:0] in_aluop, alu_op;
  logic out_valid, out_delay_slot, out_regwrite;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exec_stage #(.DW(DW), .AW(AW), .OPW(OPW), .ROW_BYTES(ROW)) dut_i (
    .clk(clk), .rst(rst), .stall(stall), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_delay_slot(in_delay_slot), .in_cause(in_cause),
    .in_regwrite(in_regwrite), .in_alusrc(in_alusrc), .in_is_hwr(in_is_hwr),
    .in_hwr_sel(in_hwr_sel), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .in_imm(in_imm), .in_aluop(in_aluop), .alu_en(alu_en), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_result(alu_result),
    .alu_discard(alu_discard), .alu_cause(alu_cause),
    .cycle_count(cycle_count), .user_local(user_local),
    .out_valid(out_valid), .out_pc(out_pc), .out_delay_slot(out_delay_slot),
    .out_cause(out_cause), .out_regwrite(out_regwrite), .out_value(out_value)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change at negedge; one edge later the register shows them
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stall = 0; flush = 0; in_valid = 1; in_pc = 32'h400; in_delay_slot = 0;
    in_cause = 0; in_regwrite = 1; in_alusrc = 0; in_is_hwr = 0; in_hwr_sel = 0;
    in_rs_val = 0; in_rt_val = 0; in_imm = 0; in_aluop = 0;
    alu_result = 0; alu_discard = 0; alu_cause = 0;
    cycle_count = 32'h0001_2345; user_local = 32'hCAFE_0001;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    tick(); tick();
    chk(out_valid, 0, "R8 reset valid");
    chk(out_cause, 0, "R8 reset cause");
    rst = 0;
  endtask

  task automatic t_basic();
    in_pc = 32'h1000; in_delay_slot = 1; in_rs_val = 10; in_rt_val = 20;
    in_imm = 99; in_aluop = 6'h21; alu_result = 32'h1234;
    #1;
    chk(alu_a, 10, "R4 operand a");
    chk(alu_b, 20, "R4 operand b from rt");
    chk(alu_op, 6'h21, "R4 opcode");
    chk(alu_en, 1, "R2 alu enabled");
    tick();
    chk(out_value, 32'h1234, "R2 value");
    chk(out_cause, 0, "R2 cause none");
    chk(out_regwrite, 1, "R3 regwrite kept");
    chk(out_valid, 1, "R8 valid");
    chk(out_pc, 32'h1000, "R7 pc");
    chk(out_delay_slot, 1, "R7 delay slot");
  endtask

  task automatic t_imm();
    in_alusrc = 1; in_imm = 32'hFFFF_FFF0; in_rt_val = 7;
    #1;
    chk(alu_b, 32'hFFFF_FFF0, "R4 operand b from imm");
    in_alusrc = 0;
  endtask

  task automatic t_alu_cause();
    alu_cause = 3'd5; alu_result = 0; in_pc = 32'h2000; in_delay_slot = 0;
    tick();
    chk(out_cause, 5, "R2 alu cause merged");
    chk(out_delay_slot, 0, "R7 delay slot clear");
    alu_cause = 0;
  endtask

  task automatic t_discard();
    alu_discard = 1;
    tick();
    chk(out_regwrite, 0, "R3 discard clears write");
    alu_discard = 0;
  endtask

  task automatic t_pending();
    in_cause = 3'd6; alu_result = 32'hDEAD_BEEF; alu_cause = 3'd5; alu_discard = 1;
    #1;
    chk(alu_en, 0, "R1 alu gated");
    tick();
    chk(out_cause, 6, "R1 cause passthrough");
    chk(out_value, 0, "R1 value forced zero");
    chk(out_regwrite, 1, "R1 discard ignored");
    in_cause = 0; alu_cause = 0; alu_discard = 0;
  endtask

  task automatic t_hwr();
    logic [DW-1:0] expv [7];
    logic [4:0]    sels [7];
    sels = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd29, 5'd7, 5'd31};
    expv = '{32'd0, 32'(ROW), 32'h0001_2345, 32'd1, 32'hCAFE_0001, 32'd0, 32'd0};
    in_is_hwr = 1; alu_result = 32'h5555_5555;
    for (int i = 0; i < 7; i++) begin
      in_hwr_sel = sels[i];
      tick();
      chk(out_value, expv[i], (i < 5) ? "R5 hwreg selector" : "R6 unused selector");
    end
    in_is_hwr = 0;
  endtask

  task automatic t_stall();
    logic [DW-1:0] held;
    alu_result = 32'h77; in_pc = 32'h3000;
    tick();
    held = out_value;
    stall = 1; alu_result = 32'h88; in_pc = 32'h3004; in_valid = 0;
    #1;
    chk(in_ready, 0, "R9 not ready");
    tick(); tick();
    chk(out_value, held, "R9 value held");
    chk(out_pc, 32'h3000, "R9 pc held");
    chk(out_valid, 1, "R9 valid held");
    stall = 0; in_valid = 1;
  endtask

  task automatic t_flush();
    stall = 1; flush = 1; in_cause = 3'd4;
    tick();
    chk(out_valid, 0, "R10 flush valid");
    chk(out_cause, 0, "R10 flush cause");
    chk(out_regwrite, 0, "R10 flush write");
    stall = 0; flush = 0; in_cause = 0;
    in_valid = 0;
    tick();
    chk(out_valid, 0, "R8 invalid input");
    in_valid = 1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_imm();
    t_alu_cause();
    t_discard();
    t_pending();
    t_hwr();
    t_stall();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule